// File: doc/BRIEF.md
# Credit-Based Transmit Shaper

This block decides when one shaped transmit queue may start its next frame. It keeps a signed credit balance that grows at a programmed idle rate while a frame waits and the queue is not sending. The balance shrinks at a programmed send rate while the queue is sending. The balance is held between an upper limit and a lower limit. A new frame may start only while the balance is zero or positive. A frame already on the wire runs to completion, because the block only decides when frames start.

The rates arrive as bandwidth figures in kbit/s. The limits arrive as byte counts. The block converts both to a fixed-point credit scale that depends on the link speed. Configuration is registered once, so the converted values take effect one cycle after the inputs change. The credit accumulator then runs in every clock cycle. When shaping is switched off, or when the instance serves queue 0, the queue behaves as a plain priority queue: credit stays at zero and any pending frame may start.

Top module: `cbs_shaper`

## Requirements
- R1: The effective idle rate is floor(idle_kbps * 1024 * F / D), truncated to SLOPE_W bits. The speed code selects F and D: code 0 is 100 Mb/s with F=4 and D=100000; code 1 is 1 Gb/s with F=8 and D=1000000; code 2 is 2.5 Gb/s with F=8 and D=2500000; code 3 is 5 Gb/s with F=32 and D=5000000; code 4 is 10 Gb/s with F=32 and D=10000000.
- R2: The effective send rate is computed in the same way from the positive send magnitude given in kbit/s.
- R3: Each credit limit equals its signed byte value times 8192, truncated to CREDIT_W bits and read as a two's-complement number.
- R4: While a frame is pending and the queue is not sending, credit rises by the idle rate in each cycle and stops at the upper limit.
- R5: While the queue is sending, credit falls by the send rate in each cycle and stops at the lower limit. A falling balance never ends the current frame.
- R6: With no frame pending and the queue not sending, credit is set to zero in one cycle if it is positive. If it is negative, it rises by the idle rate but never above zero.
- R7: tx_allowed_o is 1 exactly when a frame is pending, the queue is not sending, and credit is zero or positive.
- R8: A speed code outside 0..4 freezes credit at its current value and holds tx_allowed_o at 0.
- R9: With shaping switched off, or with QUEUE_IDX equal to 0, credit is forced to 0 and tx_allowed_o equals pending and not sending.
- R10: After reset, credit is 0 and tx_allowed_o is 0 while no frame is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| shape_en_i | input | 1 | Turns credit shaping on for this queue |
| speed_i | input | 3 | Link speed code (0..4) |
| idle_slope_i | input | SLOPE_W | Idle rate in kbit/s |
| send_slope_i | input | SLOPE_W | Send rate magnitude in kbit/s |
| hi_credit_i | input | CREDIT_W | Upper credit limit in bytes, signed |
| lo_credit_i | input | CREDIT_W | Lower credit limit in bytes, signed |
| pending_i | input | 1 | A frame is waiting in the queue |
| tx_active_i | input | 1 | The queue is sending a frame |
| tx_allowed_o | output | 1 | The next frame may start |
| credit_o | output | CREDIT_W | Current credit balance, signed |

## Verification
The accumulator is driven through four kinds of pattern, and each one separates a different kind of fault. Long waiting runs show whether the balance stops at the upper limit. Long sending runs show whether it stops at the lower limit. Idle runs that start from a positive balance and from a negative balance show the two different idle rules apart. Every speed code is tried with rates that do not divide evenly, which exposes a wrong factor, a wrong divisor or rounding in place of truncation. A byte limit is chosen so that its scaled value overflows and wraps, which tests the truncation to CREDIT_W bits. Further runs use an unsupported speed code, switch shaping off partway through, and add a second instance fixed to queue 0; in each case the bench checks that the shaping path is bypassed or frozen.

// File: rtl/cbs_pkg.sv
package cbs_pkg;
  typedef enum logic [2:0] {
    SPD_100M = 3'd0,
    SPD_1G   = 3'd1,
    SPD_2G5  = 3'd2,
    SPD_5G   = 3'd3,
    SPD_10G  = 3'd4
  } speed_e;

  typedef enum logic [2:0] {
    CS_OFF,
    CS_HOLD,
    CS_SEND,
    CS_WAIT,
    CS_FLUSH,
    CS_RECOVER
  } credit_state_e;

  localparam int unsigned LIMIT_SHIFT = 13;  // bytes * 1024 * 8

  function automatic logic [5:0] rate_factor(logic [2:0] spd);
    case (spd)
      SPD_100M:         return 6'd4;
      SPD_1G, SPD_2G5:  return 6'd8;
      SPD_5G, SPD_10G:  return 6'd32;
      default:          return 6'd0;
    endcase
  endfunction

  function automatic logic speed_supported(logic [2:0] spd);
    return spd <= SPD_10G;
  endfunction
endpackage

// File: rtl/cbs_slope_scale.sv
module cbs_slope_scale
  import cbs_pkg::*;
#(
  parameter int unsigned SLOPE_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [2:0]         speed_i,
  input  logic [SLOPE_W-1:0] kbps_i,
  output logic [SLOPE_W-1:0] slope_o,
  output logic               ok_o
);
  localparam int unsigned PW = SLOPE_W + 16;

  logic [PW-1:0] prod;
  logic [PW-1:0] quot;

  assign prod = (PW'(kbps_i) * PW'(rate_factor(speed_i))) << 10;

  always_comb begin
    case (speed_i)
      SPD_100M: quot = prod / PW'(100000);
      SPD_1G:   quot = prod / PW'(1000000);
      SPD_2G5:  quot = prod / PW'(2500000);
      SPD_5G:   quot = prod / PW'(5000000);
      SPD_10G:  quot = prod / PW'(10000000);
      default:  quot = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slope_o <= '0;
      ok_o    <= 1'b0;
    end else begin
      slope_o <= quot[SLOPE_W-1:0];
      ok_o    <= speed_supported(speed_i);
    end
  end
endmodule

// File: rtl/cbs_limit_scale.sv
module cbs_limit_scale
  import cbs_pkg::*;
#(
  parameter int unsigned CREDIT_W = 32
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic signed [CREDIT_W-1:0] bytes_i,
  output logic signed [CREDIT_W-1:0] limit_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) limit_o <= '0;
    else         limit_o <= {bytes_i[CREDIT_W-1-LIMIT_SHIFT:0], {LIMIT_SHIFT{1'b0}}};
  end
endmodule

// File: rtl/cbs_credit_acc.sv
module cbs_credit_acc
  import cbs_pkg::*;
#(
  parameter int unsigned CREDIT_W = 32,
  parameter int unsigned SLOPE_W  = 32
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       shaping_on_i,
  input  logic                       speed_ok_i,
  input  logic                       pending_i,
  input  logic                       tx_active_i,
  input  logic        [SLOPE_W-1:0]  idle_i,
  input  logic        [SLOPE_W-1:0]  send_i,
  input  logic signed [CREDIT_W-1:0] hi_i,
  input  logic signed [CREDIT_W-1:0] lo_i,
  output logic signed [CREDIT_W-1:0] credit_o
);
  localparam int unsigned AW = ((CREDIT_W > SLOPE_W) ? CREDIT_W : SLOPE_W) + 2;

  credit_state_e     state;
  logic signed [AW-1:0] c_w, idle_w, send_w, hi_w, lo_w, up_w, dn_w, nxt_w;

  assign c_w    = AW'(credit_o);
  assign hi_w   = AW'(hi_i);
  assign lo_w   = AW'(lo_i);
  assign idle_w = $signed({{(AW-SLOPE_W){1'b0}}, idle_i});
  assign send_w = $signed({{(AW-SLOPE_W){1'b0}}, send_i});
  assign up_w   = c_w + idle_w;
  assign dn_w   = c_w - send_w;

  always_comb begin
    if (!shaping_on_i)                   state = CS_OFF;
    else if (!speed_ok_i)                state = CS_HOLD;
    else if (tx_active_i)                state = CS_SEND;
    else if (pending_i)                  state = CS_WAIT;
    else if (c_w > 0)                    state = CS_FLUSH;
    else                                 state = CS_RECOVER;
  end

  always_comb begin
    case (state)
      CS_OFF:     nxt_w = '0;
      CS_HOLD:    nxt_w = c_w;
      CS_SEND:    nxt_w = (dn_w < lo_w) ? lo_w : dn_w;
      CS_WAIT:    nxt_w = (up_w > hi_w) ? hi_w : up_w;
      CS_FLUSH:   nxt_w = '0;
      default:    nxt_w = (up_w > 0) ? '0 : up_w;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) credit_o <= '0;
    else         credit_o <= nxt_w[CREDIT_W-1:0];
  end
endmodule

// File: rtl/cbs_shaper.sv
module cbs_shaper
  import cbs_pkg::*;
#(
  parameter int unsigned CREDIT_W  = 32,
  parameter int unsigned SLOPE_W   = 32,
  parameter int unsigned QUEUE_IDX = 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       shape_en_i,
  input  logic [2:0]                 speed_i,
  input  logic [SLOPE_W-1:0]         idle_slope_i,
  input  logic [SLOPE_W-1:0]         send_slope_i,
  input  logic signed [CREDIT_W-1:0] hi_credit_i,
  input  logic signed [CREDIT_W-1:0] lo_credit_i,
  input  logic                       pending_i,
  input  logic                       tx_active_i,
  output logic                       tx_allowed_o,
  output logic signed [CREDIT_W-1:0] credit_o
);
  localparam int unsigned NUM_SLOPES = 2;
  localparam int unsigned NUM_LIMITS = 2;

  logic [NUM_SLOPES-1:0][SLOPE_W-1:0]  kbps_in, slope_q;
  logic [NUM_SLOPES-1:0]               ok_q;
  logic [NUM_LIMITS-1:0][CREDIT_W-1:0] bytes_in, limit_q;
  logic signed [CREDIT_W-1:0]          hi_lim, lo_lim;
  logic                                speed_ok;
  logic                                shaping_on;

  assign kbps_in  = {send_slope_i, idle_slope_i};
  assign bytes_in = {lo_credit_i, hi_credit_i};

  for (genvar g = 0; g < NUM_SLOPES; g++) begin : g_slope
    cbs_slope_scale #(.SLOPE_W(SLOPE_W)) i_scale (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .speed_i (speed_i),
      .kbps_i  (kbps_in[g]),
      .slope_o (slope_q[g]),
      .ok_o    (ok_q[g])
    );
  end

  for (genvar g = 0; g < NUM_LIMITS; g++) begin : g_limit
    cbs_limit_scale #(.CREDIT_W(CREDIT_W)) i_limit (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .bytes_i (bytes_in[g]),
      .limit_o (limit_q[g])
    );
  end

  assign hi_lim   = $signed(limit_q[0]);
  assign lo_lim   = $signed(limit_q[1]);
  assign speed_ok = &ok_q;

  if (QUEUE_IDX == 0) begin : g_plain
    assign shaping_on = 1'b0;
  end else begin : g_shaped
    assign shaping_on = shape_en_i;
  end

  cbs_credit_acc #(.CREDIT_W(CREDIT_W), .SLOPE_W(SLOPE_W)) i_acc (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .shaping_on_i (shaping_on),
    .speed_ok_i   (speed_ok),
    .pending_i    (pending_i),
    .tx_active_i  (tx_active_i),
    .idle_i       (slope_q[0]),
    .send_i       (slope_q[1]),
    .hi_i         (hi_lim),
    .lo_i         (lo_lim),
    .credit_o     (credit_o)
  );

  // start decision only; a running frame is never revoked
  assign tx_allowed_o = pending_i && !tx_active_i &&
                        (!shaping_on || (speed_ok && !credit_o[CREDIT_W-1]));
endmodule

// File: rtl/cbs_shaper_chk.sv
module cbs_shaper_chk #(
  parameter int unsigned CREDIT_W = 32
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       shaping_on_i,
  input logic                       speed_ok_i,
  input logic                       pending_i,
  input logic                       tx_active_i,
  input logic                       tx_allowed_o,
  input logic signed [CREDIT_W-1:0] credit_i,
  input logic signed [CREDIT_W-1:0] hi_i,
  input logic signed [CREDIT_W-1:0] lo_i
);
  assert_allow_gated_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_allowed_o |-> pending_i && !tx_active_i);

  assert_neg_blocks_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shaping_on_i && credit_i < 0 |-> !tx_allowed_o);

  assert_flush_positive_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shaping_on_i && speed_ok_i && !pending_i && !tx_active_i && credit_i > 0
    |=> credit_i == 0);

  assert_bypass_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shaping_on_i |=> credit_i == 0);

  assert_freeze_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shaping_on_i && !speed_ok_i |=> $stable(credit_i));

  assert_send_falls_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shaping_on_i && speed_ok_i && tx_active_i && credit_i >= lo_i
    |=> credit_i <= $past(credit_i) && credit_i >= $past(lo_i));

  assert_wait_rises_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shaping_on_i && speed_ok_i && pending_i && !tx_active_i && credit_i <= hi_i
    |=> credit_i >= $past(credit_i) && credit_i <= $past(hi_i));
endmodule

bind cbs_shaper cbs_shaper_chk #(.CREDIT_W(CREDIT_W)) i_cbs_shaper_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .shaping_on_i (shaping_on),
  .speed_ok_i   (speed_ok),
  .pending_i    (pending_i),
  .tx_active_i  (tx_active_i),
  .tx_allowed_o (tx_allowed_o),
  .credit_i     (credit_o),
  .hi_i         (hi_lim),
  .lo_i         (lo_lim)
);

// File: tb/test_cbs_shaper.sv
`timescale 1ns/1ps
module test_cbs_shaper;
  localparam int CW = 32;
  localparam int SW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [2:0] speed = 3'd1;
  logic [SW-1:0] idle_k = '0, send_k = '0;
  logic signed [CW-1:0] hi_b = '0, lo_b = '0;
  logic pend = 1'b0, txa = 1'b0;
  logic allow, allow_q0;
  logic signed [CW-1:0] credit, credit_q0;

  always #5 clk = ~clk;

  cbs_shaper #(.CREDIT_W(CW), .SLOPE_W(SW), .QUEUE_IDX(1)) i_cbs_shaper (
    .clk_i(clk), .rst_ni(rst_n), .shape_en_i(en), .speed_i(speed),
    .idle_slope_i(idle_k), .send_slope_i(send_k),
    .hi_credit_i(hi_b), .lo_credit_i(lo_b),
    .pending_i(pend), .tx_active_i(txa),
    .tx_allowed_o(allow), .credit_o(credit));

  cbs_shaper #(.CREDIT_W(CW), .SLOPE_W(SW), .QUEUE_IDX(0)) i_cbs_shaper_q0 (
    .clk_i(clk), .rst_ni(rst_n), .shape_en_i(en), .speed_i(speed),
    .idle_slope_i(idle_k), .send_slope_i(send_k),
    .hi_credit_i(hi_b), .lo_credit_i(lo_b),
    .pending_i(pend), .tx_active_i(txa),
    .tx_allowed_o(allow_q0), .credit_o(credit_q0));

  typedef struct {
    longint credit;
    bit     allowed;
    bit     allowed_q0;
    string  req;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  longint m_idle, m_send, m_hi, m_lo, mc;
  bit m_ok;

  task automatic chk(string req, longint act, longint expv);
    checks++;
    if (act != expv) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic longint fac(int s);
    case (s)
      0: return 4;
      1, 2: return 8;
      3, 4: return 32;
      default: return 0;
    endcase
  endfunction

  function automatic longint dv(int s);
    case (s)
      0: return 100000;
      1: return 1000000;
      2: return 2500000;
      3: return 5000000;
      4: return 10000000;
      default: return 1;
    endcase
  endfunction

  function automatic longint nxt(bit e, longint c, bit p, bit t);
    longint v;
    if (!e) return 0;
    if (!m_ok) return c;
    if (t) begin v = c - m_send; return (v < m_lo) ? m_lo : v; end
    if (p) begin v = c + m_idle; return (v > m_hi) ? m_hi : v; end
    if (c > 0) return 0;
    v = c + m_idle;
    return (v > 0) ? 0 : v;
  endfunction

  // driver: applies one cycle of stimulus and queues the expected outcome
  task automatic step(bit e, bit p, bit t, string req);
    exp_t it;
    @(negedge clk);
    en = e; pend = p; txa = t;
    mc = nxt(e, mc, p, t);
    it.credit     = mc;
    it.allowed    = p && !t && (!e || (m_ok && mc >= 0));
    it.allowed_q0 = p && !t;
    it.req        = req;
    exp_q.push_back(it);
  endtask

  task automatic configure(int s, longint ik, longint sk, int hb, int lb);
    exp_t it;
    @(negedge clk);
    en = 1'b0; pend = 1'b0; txa = 1'b0;
    speed = 3'(s); idle_k = SW'(ik); send_k = SW'(sk);
    hi_b = hb; lo_b = lb;
    m_ok   = (s <= 4);
    m_idle = m_ok ? (((ik * 1024 * fac(s)) / dv(s)) & 64'hFFFF_FFFF) : 0;
    m_send = m_ok ? (((sk * 1024 * fac(s)) / dv(s)) & 64'hFFFF_FFFF) : 0;
    m_hi   = longint'(int'(longint'(hb) * 8192));
    m_lo   = longint'(int'(longint'(lb) * 8192));
    mc = 0;
    it.credit = 0; it.allowed = 1'b0; it.allowed_q0 = 1'b0; it.req = "R9";
    exp_q.push_back(it);
    step(1'b0, 1'b0, 1'b0, "R9");
  endtask

  // monitor: pops expectations one per cycle, after the edge settles
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        exp_t it;
        it = exp_q.pop_front();
        chk({it.req, " credit"}, longint'(credit), it.credit);
        chk({it.req, " tx_allowed"}, longint'(allow), longint'(it.allowed));
        chk("R9 q0 credit", longint'(credit_q0), 0);
        chk("R9 q0 tx_allowed", longint'(allow_q0), longint'(it.allowed_q0));
      end
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R10 reset credit", longint'(credit), 0);
    chk("R10 reset tx_allowed", longint'(allow), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // 1G: idle 4096, send 4096, hi 16384, lo -24576 (R1 R2 R3)
    configure(1, 500000, 500000, 2, -3);
    for (int i = 0; i < 5; i++) step(1'b1, 1'b1, 1'b0, "R4");
    for (int i = 0; i < 11; i++) step(1'b1, 1'b0, 1'b1, "R5");
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b0, "R6");
    for (int i = 0; i < 4; i++) step(1'b1, 1'b1, 1'b0, "R7");
    step(1'b1, 1'b0, 1'b0, "R6");
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b1, "R5");
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 1'b0, "R6");

    // 100M with wrapping hi limit: 0x80001*8192 -> 8192 (R3)
    configure(0, 25000, 50000, 32'h0008_0001, -1);
    for (int i = 0; i < 10; i++) step(1'b1, 1'b1, 1'b0, "R3");
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 1'b1, "R3");

    // 10G: idle 3276, send 9830 truncated (R1 R2)
    configure(4, 1000000, 3000000, 4, -4);
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b0, "R1");
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b1, "R2");

    // 2.5G and 5G factors (R1)
    configure(2, 1000000, 1000000, 1, -1);
    for (int i = 0; i < 2; i++) step(1'b1, 1'b1, 1'b0, "R1");
    configure(3, 1000000, 1500000, 1, -1);
    for (int i = 0; i < 2; i++) step(1'b1, 1'b1, 1'b0, "R1");
    step(1'b1, 1'b0, 1'b1, "R2");

    // unsupported speed code (R8)
    configure(5, 500000, 500000, 2, -3);
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b0, "R8");
    step(1'b1, 1'b0, 1'b1, "R8");

    // shaping switched off mid-run (R9)
    configure(1, 500000, 500000, 2, -3);
    for (int i = 0; i < 2; i++) step(1'b1, 1'b0, 1'b1, "R5");
    step(1'b0, 1'b1, 1'b0, "R9");
    step(1'b0, 1'b0, 1'b1, "R9");
    step(1'b1, 1'b1, 1'b0, "R9");

    while (exp_q.size() > 0) @(posedge clk);
    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule